// File: doc/BRIEF.md
# Fast-Charge Safety Timer and Host Watchdog

This block limits how long a single-cell charger may stay in fast charge. It also checks that the host keeps talking to the charger. A prescaler divides the system clock into a one-second time base. The safety timer adds up the seconds spent in fast charge and compares the total with one of three limits, chosen by a 2-bit select. A fourth select code turns the limit off. When the total reaches the selected limit, the timer latches a fault that the charger core reports as a charge fault.

If slow-down is enabled and the core reports thermal regulation or input-high protection, the timer advances only on every second tick, so the allowed charge time doubles. A new charge cycle or a charge disable clears the accumulated time and any latched fault.

A separate watchdog counts seconds since the last host reset command. When the count runs out, it emits a one-cycle pulse that tells the core to restore its default register values. The register fields that supply the limit select (default 00) and the slow-down enable (default 1) are held in the core and arrive here as plain inputs. For short simulations, all time constants are parameters.

The safety timer is a four-state machine:
- `T_IDLE`: count cleared.
- `T_RUN`: counting fast-charge time.
- `T_PAUSE`: fast charge has left, and the count is held.
- `T_FAULT`: the limit was reached.

Its transitions are:
- Restart or disable: any state goes to `T_IDLE`. This has priority over every other transition.
- `T_IDLE` → `T_RUN`: when fast charge is present.
- `T_RUN` → `T_PAUSE`: when fast charge drops.
- `T_RUN` → `T_FAULT`: when fast charge is present, the limit is enabled, and the elapsed count is at or above the selected limit.
- `T_PAUSE` → `T_RUN`: when fast charge returns.
- `T_FAULT`: stays in `T_FAULT`.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset, `tmr_fault` and `wd_expire` are both 0.
- R2: With `lim_sel` = 2'b00, `tmr_fault` rises after `LIM0_S` ticks of fast charge and not before. Once set, it stays set until a restart or a disable.
- R3: With `lim_sel` = 2'b01 the limit is `LIM1_S` ticks, and with `lim_sel` = 2'b10 it is `LIM2_S` ticks.
- R4: With `lim_sel` = 2'b11, `tmr_fault` never rises, however long fast charge lasts.
- R5: With `slow_en` = 1 and either `thermal_reg` or `vin_high` high, the count advances on every second tick, so the fault comes after twice the limit.
- R6: With `slow_en` = 0, `thermal_reg` and `vin_high` have no effect on the fault time.
- R7: The count advances only while `chg_fast` is high. Time already accumulated is kept while `chg_fast` is low. `tmr_fault` rises only in the cycle after one in which `chg_fast` was high.
- R8: A `chg_restart` or `chg_disable` pulse clears the accumulated count, and it clears `tmr_fault` by the next cycle.
- R9: When `lim_sel` changes to a limit that the accumulated count already meets, `tmr_fault` rises within two cycles.
- R10: Without `wd_kick`, `wd_expire` pulses for exactly one cycle every `WDOG_S` ticks.
- R11: `wd_kick` restarts the watchdog count. While kicks arrive more often than every `WDOG_S` ticks, `wd_expire` stays low, including in the cycle after a kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_fast | input | 1 | Charger core is in fast charge |
| chg_restart | input | 1 | One-cycle pulse: a new charge cycle starts |
| chg_disable | input | 1 | Charging is disabled |
| thermal_reg | input | 1 | Core is in thermal regulation |
| vin_high | input | 1 | Input-high protection is active |
| slow_en | input | 1 | Enables half-rate counting under thermal or input-high conditions |
| lim_sel | input | 2 | Limit select: 00 = LIM0, 01 = LIM1, 10 = LIM2, 11 = off |
| wd_kick | input | 1 | One-cycle host watchdog reset command |
| tmr_fault | output | 1 | Safety timer expired (latched) |
| wd_expire | output | 1 | One-cycle pulse: watchdog expired, restore defaults |

## Verification
The assertions make several assumptions about the inputs:
- `chg_restart` and `wd_kick` are single-cycle pulses.
- All inputs are synchronous to `clk`.
- `WDOG_S` is at least 2, so an expiry can never land in the cycle right after a kick.

The stimulus drives every input on the falling clock edge and holds it for whole cycles. It issues each restart and kick as exactly one high cycle. Limit changes are made only while fast charge is running. Because the phase of the free-running prescaler is not known to the bench, fault times are checked against a window of one tick on either side of the expected time. The spacing between two consecutive watchdog pulses is checked to the exact cycle.

// File: rtl/chg_timer_pkg.sv
package chg_timer_pkg;
    typedef enum logic [1:0] {
        T_IDLE  = 2'd0,
        T_RUN   = 2'd1,
        T_PAUSE = 2'd2,
        T_FAULT = 2'd3
    } tmr_state_t;

    localparam logic [1:0] SEL_LIM0 = 2'b00;
    localparam logic [1:0] SEL_LIM1 = 2'b01;
    localparam logic [1:0] SEL_LIM2 = 2'b10;
    localparam logic [1:0] SEL_OFF  = 2'b11;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
    parameter int DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n)                   cnt <= '0;
                else if (cnt == CW'(DIV - 1)) cnt <= '0;
                else                          cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/chg_fast_timer.sv
module chg_fast_timer
    import chg_timer_pkg::*;
#(
    parameter int LIM0_S = 1620,
    parameter int LIM1_S = 10800,
    parameter int LIM2_S = 21600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       chg_fast,
    input  logic       chg_restart,
    input  logic       chg_disable,
    input  logic       slow,
    input  logic [1:0] lim_sel,
    output logic       tmr_fault
);
    localparam int MAXL = max3(LIM0_S, LIM1_S, LIM2_S);
    localparam int EW   = $clog2(MAXL + 1) + 1;

    tmr_state_t    st, nxt;
    logic [EW-1:0] elapsed;
    logic [EW-1:0] limit;
    logic          armed;
    logic          half_ph;
    logic          clr;

    assign clr = chg_restart | chg_disable;

    always_comb begin
        armed = 1'b1;
        unique case (lim_sel)
            SEL_LIM0: limit = EW'(LIM0_S);
            SEL_LIM1: limit = EW'(LIM1_S);
            SEL_LIM2: limit = EW'(LIM2_S);
            default: begin
                limit = '1;
                armed = 1'b0;
            end
        endcase
    end

    always_comb begin
        nxt = st;
        if (clr) begin
            nxt = T_IDLE;
        end else begin
            unique case (st)
                T_IDLE:  if (chg_fast) nxt = T_RUN;
                T_RUN: begin
                    if (!chg_fast)                         nxt = T_PAUSE;
                    else if (armed && (elapsed >= limit))  nxt = T_FAULT;
                end
                T_PAUSE: if (chg_fast) nxt = T_RUN;
                T_FAULT: nxt = T_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            elapsed <= '0;
            half_ph <= 1'b0;
        end else if (st != T_RUN) begin
            half_ph <= 1'b0;
        end else if (tick) begin
            if (slow) begin
                half_ph <= ~half_ph;
                if (half_ph && (elapsed != '1)) elapsed <= elapsed + 1'b1;
            end else begin
                half_ph <= 1'b0;
                if (elapsed != '1) elapsed <= elapsed + 1'b1;
            end
        end
    end

    always_comb begin
        tmr_fault = (st == T_FAULT);
    end
endmodule

// File: rtl/chg_host_wdog.sv
module chg_host_wdog #(
    parameter int WDOG_S = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wd_kick,
    output logic wd_expire
);
    localparam int WW = (WDOG_S > 1) ? $clog2(WDOG_S) : 1;
    logic [WW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            wd_expire <= 1'b0;
        end else if (wd_kick) begin
            cnt       <= '0;
            wd_expire <= 1'b0;
        end else if (tick) begin
            if (cnt == WW'(WDOG_S - 1)) begin
                cnt       <= '0;
                wd_expire <= 1'b1;
            end else begin
                cnt       <= cnt + 1'b1;
                wd_expire <= 1'b0;
            end
        end else begin
            wd_expire <= 1'b0;
        end
    end
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
    parameter int TICK_DIV = 100_000_000,
    parameter int LIM0_S   = 1620,
    parameter int LIM1_S   = 10800,
    parameter int LIM2_S   = 21600,
    parameter int WDOG_S   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_fast,
    input  logic       chg_restart,
    input  logic       chg_disable,
    input  logic       thermal_reg,
    input  logic       vin_high,
    input  logic       slow_en,
    input  logic [1:0] lim_sel,
    input  logic       wd_kick,
    output logic       tmr_fault,
    output logic       wd_expire
);
    logic tick;
    logic slow;

    assign slow = slow_en & (thermal_reg | vin_high);

    chg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    chg_fast_timer #(
        .LIM0_S (LIM0_S),
        .LIM1_S (LIM1_S),
        .LIM2_S (LIM2_S)
    ) u_fast (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .chg_fast    (chg_fast),
        .chg_restart (chg_restart),
        .chg_disable (chg_disable),
        .slow        (slow),
        .lim_sel     (lim_sel),
        .tmr_fault   (tmr_fault)
    );

    chg_host_wdog #(.WDOG_S(WDOG_S)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wd_kick   (wd_kick),
        .wd_expire (wd_expire)
    );
endmodule

// File: rtl/chg_safety_timer_chk.sv
module chg_safety_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_fast,
    input logic       chg_restart,
    input logic       chg_disable,
    input logic [1:0] lim_sel,
    input logic       wd_kick,
    input logic       tmr_fault,
    input logic       wd_expire
);
    // R10
    wd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !wd_expire);

    // R11
    wd_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_kick |=> !wd_expire);

    // R4
    off_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_fault) |-> ($past(lim_sel) != 2'b11));

    // R8
    clear_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_restart || chg_disable) |=> !tmr_fault);

    // R2
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_fault && !chg_restart && !chg_disable) |=> tmr_fault);

    // R7
    fault_in_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_fault) |-> $past(chg_fast));
endmodule

bind chg_safety_timer chg_safety_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_fast    (chg_fast),
    .chg_restart (chg_restart),
    .chg_disable (chg_disable),
    .lim_sel     (lim_sel),
    .wd_kick     (wd_kick),
    .tmr_fault   (tmr_fault),
    .wd_expire   (wd_expire)
);

// File: tb/chg_safety_timer_test.sv
module chg_safety_timer_test;
    localparam int DIV = 4;
    localparam int L0  = 20;
    localparam int L1  = 40;
    localparam int L2  = 60;
    localparam int W   = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chg_fast = 1'b0, chg_restart = 1'b0, chg_disable = 1'b0;
    logic       thermal_reg = 1'b0, vin_high = 1'b0, slow_en = 1'b1;
    logic [1:0] lim_sel = 2'b00;
    logic       wd_kick = 1'b0;
    logic       tmr_fault, wd_expire;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    chg_safety_timer #(
        .TICK_DIV (DIV), .LIM0_S (L0), .LIM1_S (L1), .LIM2_S (L2), .WDOG_S (W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .chg_fast (chg_fast),
        .chg_restart (chg_restart), .chg_disable (chg_disable),
        .thermal_reg (thermal_reg), .vin_high (vin_high), .slow_en (slow_en),
        .lim_sel (lim_sel), .wd_kick (wd_kick),
        .tmr_fault (tmr_fault), .wd_expire (wd_expire)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_fast(input logic [1:0] sel, input logic sen,
                              input logic th, input logic vh);
        @(negedge clk);
        lim_sel = sel; slow_en = sen; thermal_reg = th; vin_high = vh;
        chg_fast = 1'b0; chg_restart = 1'b1;
        @(negedge clk);
        chg_restart = 1'b0; chg_fast = 1'b1;
    endtask

    task automatic fault_window(input string req, input int ticks);
        cyc((ticks - 1) * DIV - 2);
        chk({req, " early"}, tmr_fault, 1'b0);
        cyc(DIV + 6);
        chk({req, " expired"}, tmr_fault, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1 fault", tmr_fault, 1'b0);
        chk("R1 wdog", wd_expire, 1'b0);
    endtask

    task automatic t_limits;
        start_fast(2'b00, 1'b1, 1'b0, 1'b0);
        fault_window("R2 lim0", L0);
        cyc(50);
        chk("R2 hold", tmr_fault, 1'b1);
        start_fast(2'b01, 1'b1, 1'b0, 1'b0);
        fault_window("R3 lim1", L1);
        start_fast(2'b10, 1'b1, 1'b0, 1'b0);
        fault_window("R3 lim2", L2);
    endtask

    task automatic t_off_and_switch;
        start_fast(2'b11, 1'b1, 1'b0, 1'b0);
        cyc(100 * DIV);
        chk("R4 off", tmr_fault, 1'b0);
        lim_sel = 2'b00;
        cyc(3);
        chk("R9 off to lim0", tmr_fault, 1'b1);
        start_fast(2'b10, 1'b1, 1'b0, 1'b0);
        cyc(30 * DIV);
        chk("R9 before switch", tmr_fault, 1'b0);
        lim_sel = 2'b00;
        cyc(3);
        chk("R9 switch lim2 to lim0", tmr_fault, 1'b1);
    endtask

    task automatic t_slow;
        start_fast(2'b00, 1'b1, 1'b1, 1'b0);
        fault_window("R5 thermal half rate", 2 * L0);
        start_fast(2'b00, 1'b1, 1'b0, 1'b1);
        fault_window("R5 vin_high half rate", 2 * L0);
        start_fast(2'b00, 1'b0, 1'b1, 1'b1);
        fault_window("R6 slow disabled", L0);
    endtask

    task automatic t_pause_clear;
        start_fast(2'b00, 1'b1, 1'b0, 1'b0);
        cyc(10 * DIV);
        chg_fast = 1'b0;
        cyc(30 * DIV);
        chk("R7 paused", tmr_fault, 1'b0);
        chg_fast = 1'b1;
        cyc(8 * DIV - 2);
        chk("R7 resume early", tmr_fault, 1'b0);
        cyc(4 * DIV + 6);
        chk("R7 resume expired", tmr_fault, 1'b1);
        chg_disable = 1'b1;
        cyc(1);
        chg_disable = 1'b0;
        chk("R8 disable clears", tmr_fault, 1'b0);
        chg_fast = 1'b1;
        cyc((L0 - 1) * DIV - 2);
        chk("R8 count cleared", tmr_fault, 1'b0);
        chg_restart = 1'b1;
        cyc(1);
        chg_restart = 1'b0;
        chk("R8 restart", tmr_fault, 1'b0);
    endtask

    task automatic t_wdog;
        int first = -1;
        int second = -1;
        @(negedge clk);
        wd_kick = 1'b1;
        @(negedge clk);
        wd_kick = 1'b0;
        chk("R11 after kick", wd_expire, 1'b0);
        for (int i = 1; i <= (2 * W + 3) * DIV; i++) begin
            @(negedge clk);
            if (wd_expire) begin
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
            if (first == i - 1 && first > 0)
                chk("R10 single cycle", wd_expire, 1'b0);
        end
        chk_int("R10 first pulse", first, (W - 1) * DIV, W * DIV + 2);
        chk_int("R10 period", second - first, W * DIV, W * DIV);
        begin
            int seen = 0;
            for (int i = 0; i < 4 * W * DIV; i++) begin
                @(negedge clk);
                if (wd_expire) seen++;
                wd_kick = (i % (5 * DIV) == 0);
            end
            @(negedge clk);
            wd_kick = 1'b0;
            chk_int("R11 kicked no expiry", seen, 0, 0);
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_limits();
        t_off_and_switch();
        t_slow();
        t_pause_clear();
        t_wdog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule